// File: doc/BRIEF.md
# I2C Master Byte Engine with Data FIFOs

This block is an I2C bus master that software drives through a small 32-bit register window. Software loads a 7-bit target address, a direction, a byte count and a stop choice. It fills a 16-byte transmit queue for writes and then sets a start bit. The engine issues a START condition and the address byte. It then moves exactly the requested number of data bytes, taking them from the transmit queue or placing them in a 16-byte receive queue. At the end it either releases the bus with STOP or keeps SCL low so that the next transfer opens with a repeated START.

Bit timing is not generated here. A separate timing block supplies `bit_tick`, a strobe at four times the SCL rate. Each bit uses four ticks: data set-up with SCL low, SCL release, sampling while SCL is high, and SCL pull-down. The engine drives both bus lines as open-drain outputs, where an enable means "pull low", and it reads the live line levels back. One interrupt output combines a sticky transfer-done flag with two FIFO level interrupts whose thresholds software programs.

Register offsets: control 0x00, target 0x04, byte count 0x08, transmit data 0x0C (write), receive data 0x10 (read), status 0x14, FIFO flush 0x18.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0x0030_0008: SDA live (bit 21) and SCL live (bit 20) are high, transmit-queue-empty (bit 3) is set, and busy (bit 0), received-NACK (bit 1), interrupt-pending (bit 2) and receive-queue-full (bit 4) are clear. Both bus lines are released and `irq` is low.
- R2: The first byte after START is the target register's bits 7:1 followed by control bit 3 as the R/W bit (1 = read, 0 = write). SDA changes only while SCL is low during address and data bits.
- R3: Setting control bit 0 from 0 to 1 while idle starts a transfer. On a write, exactly the count register's number of bytes leave the transmit queue in order, each MSB first. With control bit 20 set, a STOP follows. On completion busy clears and interrupt-pending sets.
- R4: On a read, exactly the count register's number of bytes enter the receive queue in order. The master ACKs each byte except the last, which it NACKs.
- R5: If the target NACKs the address or a written byte, status bit 1 sets, no further byte is sent, and the transfer ends with STOP and interrupt-pending.
- R6: With control bit 20 clear, no STOP is sent after the last byte. SCL is held low and busy clears. The next start produces a repeated START with no STOP in between.
- R7: Status bits 1 and 2 stay set until software writes 0 to them. Writing 1 to either leaves it unchanged.
- R8: `irq` is high exactly when control bit 1 is set and at least one of these holds: interrupt-pending is set; control bit 9 is set and the transmit level is at or below control bits 15:12; control bit 10 is set and the receive level is at or above control bits 19:16.
- R9: Writing 1 to bit 0 of the flush register empties both queues.
- R10: Each queue holds 16 bytes. A write to a full transmit queue is dropped, and a read of an empty receive queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after `bus_rd` |
| bit_tick | input | 1 | Quarter-bit strobe from the timing block |
| scl_i | input | 1 | Live SCL level |
| sda_i | input | 1 | Live SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach from the ports is a repeated START. It needs a write that ends with the bus held low and no STOP, followed by a read that must open with a fresh START. The bench's bus target model counts START and STOP conditions separately, so it can confirm that the two transfers were joined without a STOP. A second hard case is a target NACK in the middle of a write, after some bytes have already been accepted. The target model is told which byte to refuse, and the bench then checks how many bytes arrived and that STOP followed. Queue overflow is reached by pushing more bytes than the queue holds and then sending a full queue's worth.

// File: rtl/i2c_byte_master_pkg.sv
package i2c_byte_master_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 5'h00;
  localparam logic [REG_AW-1:0] OFF_TARGET = 5'h04;
  localparam logic [REG_AW-1:0] OFF_COUNT  = 5'h08;
  localparam logic [REG_AW-1:0] OFF_TXDATA = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_RXDATA = 5'h10;
  localparam logic [REG_AW-1:0] OFF_STATUS = 5'h14;
  localparam logic [REG_AW-1:0] OFF_FLUSH  = 5'h18;

  localparam int CB_GO    = 0;
  localparam int CB_IEN   = 1;
  localparam int CB_RD    = 3;
  localparam int CB_TXIE  = 9;
  localparam int CB_RXIE  = 10;
  localparam int CB_TXLO  = 12;
  localparam int CB_RXLO  = 16;
  localparam int CB_STOP  = 20;
  localparam logic [31:0] CTRL_MASK = 32'h001F_F60B;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_DATA, S_STOP, S_HOLD
  } eng_state_e;
endpackage

// File: rtl/ibm_fifo.sv
module ibm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic [$clog2(DEPTH):0] count,
  output logic            empty,
  output logic            full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (count == $past(count)));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/ibm_engine.sv
module ibm_engine
  import i2c_byte_master_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          go,
  input  logic          rw,
  input  logic [6:0]    addr7,
  input  logic [CW-1:0] nbytes,
  input  logic          stop_en,
  input  logic          tx_empty,
  input  logic [7:0]    tx_data,
  input  logic          sda_i,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [7:0]    rx_data,
  output logic          busy,
  output logic          done,
  output logic          nack_ev,
  output logic          scl_oe,
  output logic          sda_oe
);
  eng_state_e    st;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic [CW-1:0] left;
  logic          rd_q, stp_q, ack_q;
  logic          wdat, rdat, stall;

  assign busy  = (st != S_IDLE) && (st != S_HOLD);
  assign wdat  = (st == S_DATA) && !rd_q;
  assign rdat  = (st == S_DATA) && rd_q;
  assign stall = wdat && (bitn == 4'd0) && (ph == 2'd0) && tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; left <= '0;
      rd_q <= 1'b0; stp_q <= 1'b0; ack_q <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      tx_pop <= 1'b0; rx_push <= 1'b0; rx_data <= '0;
      done <= 1'b0; nack_ev <= 1'b0;
    end else begin
      tx_pop <= 1'b0; rx_push <= 1'b0; done <= 1'b0; nack_ev <= 1'b0;
      if (go && !busy) begin
        st <= S_START; ph <= '0;
        rd_q <= rw; stp_q <= stop_en; left <= nbytes;
      end else if (tick) begin
        case (st)
          S_START: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1; st <= S_ADDR; bitn <= '0; sh <= {addr7, rd_q};
              end
            endcase
          end
          S_ADDR, S_DATA: begin
            if (!stall) ph <= ph + 2'd1;
            case (ph)
              2'd0: begin
                if (bitn == 4'd8)          sda_oe <= rdat ? (left != CW'(1)) : 1'b0;
                else if (rdat)             sda_oe <= 1'b0;
                else if (wdat && bitn == 4'd0) begin
                  if (!tx_empty) begin
                    sh <= tx_data; sda_oe <= ~tx_data[7]; tx_pop <= 1'b1;
                  end
                end else                   sda_oe <= ~sh[7];
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) ack_q <= sda_i;
                else              sh <= {sh[6:0], sda_i};
              end
              default: begin
                scl_oe <= 1'b1;
                if (rdat && bitn == 4'd7) begin
                  rx_push <= 1'b1; rx_data <= sh;
                end
                if (bitn != 4'd8) bitn <= bitn + 4'd1;
                else begin
                  bitn <= '0;
                  if (ack_q && !rdat) begin
                    nack_ev <= 1'b1; st <= S_STOP;
                  end else if (st == S_ADDR) begin
                    if (left == '0) begin
                      if (stp_q) st <= S_STOP;
                      else begin st <= S_HOLD; done <= 1'b1; end
                    end else st <= S_DATA;
                  end else begin
                    left <= left - CW'(1);
                    if (left == CW'(1)) begin
                      if (stp_q) st <= S_STOP;
                      else begin st <= S_HOLD; done <= 1'b1; end
                    end
                  end
                end
              end
            endcase
          end
          S_STOP: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin st <= S_IDLE; done <= 1'b1; end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a held bus keeps SCL pulled low
  p_hold_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD) |-> scl_oe);
  // R2: SDA moves only with SCL low during address and data bits
  p_sda_under_low_scl_r2: assert property (@(posedge clk) disable iff (rst)
    ((st == S_ADDR || st == S_DATA) && ($past(st) == st) && (sda_oe != $past(sda_oe)))
      |-> $past(scl_oe));
  // R3: each popped byte belongs to a write
  p_pop_only_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (wdat && !rx_push));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_byte_master_pkg::*;
#(
  parameter int CW    = 16,
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        bit_tick,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [31:0]   ctrl_q;
  logic [7:0]    tgt_q;
  logic [CW-1:0] cnt_q;
  logic          nack_q, int_q;
  logic          go, flush, tx_push, rx_pop;
  logic          tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
  logic [7:0]    tx_dout, rx_din, rx_dout;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          e_busy, e_done, e_nack;
  logic          tx_low, rx_high;

  assign go      = bus_wr && bus_addr == OFF_CTRL && bus_wdata[CB_GO] && !ctrl_q[CB_GO];
  assign flush   = bus_wr && bus_addr == OFF_FLUSH && bus_wdata[0];
  assign tx_push = bus_wr && bus_addr == OFF_TXDATA;
  assign rx_pop  = bus_rd && bus_addr == OFF_RXDATA;
  assign tx_low  = tx_lvl <= LW'(ctrl_q[CB_TXLO +: 4]);
  assign rx_high = rx_lvl >= LW'(ctrl_q[CB_RXLO +: 4]);

  ibm_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(flush), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_lvl), .empty(tx_empty), .full(tx_full));

  ibm_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(flush), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .count(rx_lvl), .empty(rx_empty), .full(rx_full));

  ibm_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst(rst), .tick(bit_tick), .go(go), .rw(ctrl_q[CB_RD]),
    .addr7(tgt_q[7:1]), .nbytes(cnt_q), .stop_en(ctrl_q[CB_STOP]),
    .tx_empty(tx_empty), .tx_data(tx_dout), .sda_i(sda_i),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_din),
    .busy(e_busy), .done(e_done), .nack_ev(e_nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; tgt_q <= '0; cnt_q <= '0;
      nack_q <= 1'b0; int_q <= 1'b0; irq <= 1'b0; bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == OFF_CTRL)   ctrl_q <= bus_wdata & CTRL_MASK;
      if (bus_wr && bus_addr == OFF_TARGET) tgt_q  <= bus_wdata[7:0];
      if (bus_wr && bus_addr == OFF_COUNT)  cnt_q  <= bus_wdata[CW-1:0];
      if (bus_wr && bus_addr == OFF_STATUS) begin
        nack_q <= nack_q & bus_wdata[1];
        int_q  <= int_q  & bus_wdata[2];
      end
      if (e_nack) nack_q <= 1'b1;
      if (e_done) int_q  <= 1'b1;
      irq <= ctrl_q[CB_IEN] & (int_q | (ctrl_q[CB_TXIE] & tx_low) | (ctrl_q[CB_RXIE] & rx_high));
      if (bus_rd) begin
        case (bus_addr)
          OFF_CTRL:   bus_rdata <= ctrl_q;
          OFF_TARGET: bus_rdata <= {24'd0, tgt_q};
          OFF_COUNT:  bus_rdata <= 32'(cnt_q);
          OFF_RXDATA: bus_rdata <= rx_empty ? 32'd0 : {24'd0, rx_dout};
          OFF_STATUS: bus_rdata <= {10'd0, sda_i, scl_i, 15'd0,
                                    rx_full, tx_empty, int_q, nack_q, e_busy};
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  // R7: received-NACK survives anything but a write of 0
  p_nack_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (nack_q && !(bus_wr && bus_addr == OFF_STATUS && !bus_wdata[1])) |=> nack_q);
  // R3: completion always leaves interrupt-pending set
  p_done_sets_pending_r3: assert property (@(posedge clk) disable iff (rst)
    e_done |=> int_q);
  // R8: no interrupt while the global enable is clear
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_IEN] |=> !irq);
endmodule

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  localparam logic [4:0] A_CTRL = 5'h00, A_TGT = 5'h04, A_CNT = 5'h08,
    A_TX = 5'h0C, A_RX = 5'h10, A_ST = 5'h14, A_FL = 5'h18;

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0, bit_tick = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic scl_oe, sda_oe, irq;
  logic drv = 0;
  wire scl_w = !(scl_oe === 1'b1);
  wire sda_w = !((sda_oe === 1'b1) || drv);

  int checks = 0, errors = 0;
  bit finished = 0;

  i2c_byte_master uut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bit_tick(bit_tick), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  always #4 clk = ~clk;
  initial forever begin @(negedge clk); bit_tick = ~bit_tick; end

  function automatic logic [7:0] rpat(int i);
    return 8'(8'h3C + i * 29);
  endfunction

  // target model
  int starts = 0, stops = 0, bitc = 0, widx = 0, ridx = 0, nack_at = -1;
  bit skipf = 0, in_addr = 0, reading = 0;
  logic [7:0] sh = 0, got_addr = 0, rbyte = 0;
  logic [7:0] wlog [32];
  logic mack [32];

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    starts++; bitc = 0; skipf = 1; in_addr = 1; drv = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    stops++; bitc = 0; drv = 0;
  end
  always @(posedge scl_w) begin
    if (bitc < 8) sh = {sh[6:0], sda_w};
    else if (reading && !in_addr && ridx < 32) mack[ridx] = sda_w;
  end
  always @(negedge scl_w) begin
    if (skipf) skipf = 0;
    else if (bitc < 7) begin
      bitc++;
      if (reading && !in_addr) drv = ~rbyte[7 - bitc];
    end else if (bitc == 7) begin
      bitc = 8;
      if (in_addr) begin got_addr = sh; reading = sh[0]; drv = 1; end
      else if (!reading) begin
        if (widx < 32) wlog[widx] = sh;
        drv = (widx != nack_at); widx++;
      end else drv = 0;
    end else begin
      bitc = 0;
      if (in_addr) begin
        in_addr = 0;
        if (reading) begin rbyte = rpat(ridx); drv = ~rbyte[7]; end else drv = 0;
      end else if (reading) begin
        ridx++;
        if (mack[ridx-1] == 1'b0) begin rbyte = rpat(ridx); drv = ~rbyte[7]; end
        else drv = 0;
      end else drv = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic xfer(input logic [6:0] a, input bit rw, input int n, input bit stp, output bit ok);
    logic [31:0] base, s;
    widx = 0; ridx = 0;
    base = 32'h2 | (32'(rw) << 3) | (32'(stp) << 20);
    wr(A_ST, 0); wr(A_TGT, {24'd0, a, 1'b0}); wr(A_CNT, n);
    wr(A_CTRL, base); wr(A_CTRL, base | 1);
    ok = 0;
    for (int k = 0; k < 4000; k++) begin
      rd(A_ST, s);
      if (s[2]) begin ok = 1; break; end
    end
    wr(A_CTRL, base);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    bit ok;
    int n, st0, sp0;
    logic [7:0] dat [16];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(A_ST, s);
    chk(s == 32'h0030_0008, "R1 status", s, 32'h0030_0008);
    chk(irq == 0 && scl_w && sda_w, "R1 lines/irq", {irq, scl_w, sda_w}, 3'b011);

    // R2 R3 random writes
    for (int it = 0; it < 6; it++) begin
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) begin dat[i] = 8'($urandom); wr(A_TX, {24'd0, dat[i]}); end
      sp0 = stops;
      xfer(7'h50 + 7'(it), 0, n, 1, ok);
      chk(ok, "R3 done", ok, 1);
      chk(got_addr == {7'h50 + 7'(it), 1'b0}, "R2 write address", got_addr, {7'h50 + 7'(it), 1'b0});
      chk(widx == n, "R3 byte count", widx, n);
      for (int i = 0; i < n; i++)
        if (wlog[i] != dat[i]) chk(0, "R3 data", wlog[i], dat[i]);
      chk(stops == sp0 + 1, "R3 stop", stops - sp0, 1);
      rd(A_ST, s);
      chk(s[0] == 0 && s[2] == 1, "R3 busy clear, pending set", s[2:0], 3'b100);
    end

    // R7 sticky pending
    wr(A_ST, 32'h6); rd(A_ST, s);
    chk(s[2] == 1, "R7 write 1 keeps pending", s[2], 1);
    wr(A_ST, 0); rd(A_ST, s);
    chk(s[2] == 0, "R7 write 0 clears pending", s[2], 0);

    // R4 random reads
    for (int it = 0; it < 4; it++) begin
      n = 1 + int'($urandom % 12);
      xfer(7'h21, 1, n, 1, ok);
      chk(ok && got_addr == 8'h43, "R2 read address", got_addr, 8'h43);
      for (int i = 0; i < n; i++) begin
        rd(A_RX, d);
        if (d[7:0] != rpat(i)) chk(0, "R4 rx data", d, rpat(i));
        if (mack[i] != (i == n - 1)) chk(0, "R4 master ack", mack[i], (i == n - 1));
      end
      chk(ridx == n, "R4 bytes read", ridx, n);
    end

    // R5 NACK mid-write
    for (int i = 0; i < 5; i++) wr(A_TX, 32'h10 + i);
    nack_at = 2; sp0 = stops;
    xfer(7'h11, 0, 5, 1, ok);
    nack_at = -1;
    rd(A_ST, s);
    chk(s[1] == 1, "R5 nack status", s[1], 1);
    chk(widx == 3, "R5 bytes before nack", widx, 3);
    chk(stops == sp0 + 1, "R5 stop after nack", stops - sp0, 1);
    wr(A_ST, 32'h2); rd(A_ST, s);
    chk(s[1] == 1, "R7 nack sticky", s[1], 1);
    wr(A_FL, 1);

    // R6 repeated start
    wr(A_TX, 32'hA1); wr(A_TX, 32'hB2);
    st0 = starts; sp0 = stops;
    xfer(7'h33, 0, 2, 0, ok);
    repeat (20) @(negedge clk);
    rd(A_ST, s);
    chk(stops == sp0 && scl_w == 0, "R6 bus held", {stops - sp0, scl_w}, 0);
    chk(s[0] == 0, "R6 busy clear", s[0], 0);
    xfer(7'h33, 1, 3, 1, ok);
    chk(starts == st0 + 2 && stops == sp0 + 1, "R6 repeated start", starts - st0, 2);
    for (int i = 0; i < 3; i++) begin
      rd(A_RX, d);
      if (d[7:0] != rpat(i)) chk(0, "R6 rx data", d, rpat(i));
    end

    // R8 thresholds and R9 flush
    wr(A_ST, 0);
    wr(A_CTRL, 32'h2 | (1 << 9) | (4 << 12));
    repeat (3) @(negedge clk);
    chk(irq == 1, "R8 tx low irq", irq, 1);
    for (int i = 0; i < 6; i++) wr(A_TX, i);
    repeat (3) @(negedge clk);
    chk(irq == 0, "R8 tx above level", irq, 0);
    wr(A_FL, 1); rd(A_ST, s);
    chk(s[3] == 1, "R9 tx flushed", s[3], 1);
    xfer(7'h44, 1, 5, 1, ok);
    wr(A_ST, 0);
    wr(A_CTRL, 32'h2 | (1 << 10) | (5 << 16));
    repeat (3) @(negedge clk);
    chk(irq == 1, "R8 rx level irq", irq, 1);
    wr(A_CTRL, 32'h2 | (1 << 10) | (6 << 16));
    repeat (3) @(negedge clk);
    chk(irq == 0, "R8 rx below level", irq, 0);
    wr(A_CTRL, 32'h0 | (1 << 10) | (5 << 16));
    repeat (3) @(negedge clk);
    chk(irq == 0, "R8 global enable off", irq, 0);
    wr(A_FL, 1); rd(A_RX, d);
    chk(d == 0, "R9 rx flushed / R10 empty read", d, 0);

    // R10 overflow dropped
    for (int i = 0; i < 20; i++) wr(A_TX, 32'h80 + i);
    xfer(7'h55, 0, 16, 1, ok);
    chk(widx == 16, "R10 count", widx, 16);
    for (int i = 0; i < 16; i++)
      if (wlog[i] != 8'(8'h80 + i)) chk(0, "R10 kept order", wlog[i], 8'h80 + i);
    rd(A_ST, s);
    chk(s[3] == 1, "R10 extra bytes dropped", s[3], 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule